// File: doc/BRIEF.md
# Flash Polling Status Word Generator

This block models the status word that a parallel NOR flash model returns on its data bus while an embedded program or erase runs, or while an erase sits suspended. A host poller in a testbench drives read cycles with a strobe and an address. The block answers each read with an 8-bit status byte. Two toggle bits carry the mode: one flips while any embedded operation runs, the other flips only for reads that land in the sector chosen for erase. A host needs both bits to tell an active erase from a suspended one, and to tell which sector is affected.

When nothing is running or suspended, the block drops its valid flag. The surrounding model then returns array data. Both toggle states advance once per read cycle, when the strobe falls, so two back-to-back reads always differ while toggling.

Top module: `flash_poll_status`

## Requirements
- R1: After reset both toggle states are 0. With all mode flags low, `statusValid` is 0 and `statusData` is 0.
- R2: While `progActive` or `eraseActive` is high, bit 6 of `statusData` inverts after each completed read cycle.
- R3: While neither `progActive` nor `eraseActive` is high, bit 6 keeps its value across read cycles, including in erase-suspend.
- R4: Bit 2 inverts after a read whose address sector (`rdAddr` bits ADDR_W-1 down to SECTOR_SHIFT) equals `eraseSector`. This applies while `eraseActive` or `eraseSuspended` is high.
- R5: Bit 2 keeps its value after reads outside the selected sector, and after any read while no erase is active or suspended (program only).
- R6: Bit 7 is the inverse of `lastBit7` while `progActive` is high. With only an erase active it is 0. With only erase-suspend it is 1.
- R7: Bit 5 equals `timeoutFlag` while an operation is active, and is 0 otherwise.
- R8: Bit 1 equals `bufAbort` while `progActive` is high, and is 0 otherwise.
- R9: `statusValid` is high exactly when `progActive`, `eraseActive` or `eraseSuspended` is high. While it is low, `statusData` is 0. Bits 4, 3 and 0 are always 0.
- R10: A read cycle advances the toggle states once, when `rdStrobe` falls, however many cycles the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | High for the duration of a read cycle |
| rdAddr | input | ADDR_W | Read address |
| eraseSector | input | ADDR_W-SECTOR_SHIFT | Sector selected for erase |
| progActive | input | 1 | Embedded program running |
| eraseActive | input | 1 | Embedded erase running |
| eraseSuspended | input | 1 | Erase suspended |
| timeoutFlag | input | 1 | Operation exceeded its time limit |
| bufAbort | input | 1 | Write-to-buffer abort |
| lastBit7 | input | 1 | Bit 7 of the last word loaded for programming |
| statusData | output | 8 | Status byte |
| statusValid | output | 1 | Status is shown (low means return array data) |

## Verification
The assertions assume that the mode flags hold steady across a read cycle and through the cycle after the strobe falls. A real device changes mode only between polls, so this matches how it is used. The bench changes flags only while the strobe is low and at least one cycle after the last fall. The address is held for the whole time the strobe is high, so the sector compare uses the address of that read.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef struct packed {
    logic advBusy;   // flip the operation toggle
    logic advSector; // flip the sector toggle
  } pollStrobe_t;
endpackage

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SECTOR_SHIFT = 8,
  localparam int SECT_W      = ADDR_W - SECTOR_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [SECT_W-1:0] eraseSector,
  input  logic              progActive,
  input  logic              eraseActive,
  input  logic              eraseSuspended,
  output pollStrobe_t       strobes
);
  logic              strobeQ;
  logic [SECT_W-1:0] sectHold;
  logic              readEnd;
  logic              opBusy;
  logic              erasePending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobeQ  <= 1'b0;
      sectHold <= '0;
    end else begin
      strobeQ <= rdStrobe;
      if (rdStrobe) sectHold <= rdAddr[ADDR_W-1:SECTOR_SHIFT];
    end
  end

  always_comb begin
    readEnd           = strobeQ && !rdStrobe;
    opBusy            = progActive || eraseActive;
    erasePending      = eraseActive || eraseSuspended;
    strobes.advBusy   = readEnd && opBusy;
    strobes.advSector = readEnd && erasePending && (sectHold == eraseSector);
  end
endmodule

// File: rtl/poll_datapath.sv
module poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pollStrobe_t       strobes,
  input  logic              progActive,
  input  logic              eraseActive,
  input  logic              eraseSuspended,
  input  logic              timeoutFlag,
  input  logic              bufAbort,
  input  logic              lastBit7,
  output logic [DATA_W-1:0] statusData,
  output logic              statusValid
);
  logic opTog;
  logic secTog;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opTog  <= 1'b0;
      secTog <= 1'b0;
    end else begin
      if (strobes.advBusy)   opTog  <= !opTog;
      if (strobes.advSector) secTog <= !secTog;
    end
  end

  always_comb begin
    word = '0;
    if (progActive)       word[7] = !lastBit7;
    else if (eraseActive) word[7] = 1'b0;
    else                  word[7] = 1'b1;
    word[6] = opTog;
    word[5] = timeoutFlag && (progActive || eraseActive);
    word[2] = secTog;
    word[1] = bufAbort && progActive;
    statusValid = progActive || eraseActive || eraseSuspended;
    statusData  = statusValid ? word : '0;
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SECTOR_SHIFT = 8,
  localparam int SECT_W      = ADDR_W - SECTOR_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [SECT_W-1:0] eraseSector,
  input  logic              progActive,
  input  logic              eraseActive,
  input  logic              eraseSuspended,
  input  logic              timeoutFlag,
  input  logic              bufAbort,
  input  logic              lastBit7,
  output logic [7:0]        statusData,
  output logic              statusValid
);
  pollStrobe_t strobes;

  poll_ctrl #(.ADDR_W(ADDR_W), .SECTOR_SHIFT(SECTOR_SHIFT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .eraseSector(eraseSector), .progActive(progActive),
    .eraseActive(eraseActive), .eraseSuspended(eraseSuspended),
    .strobes(strobes)
  );

  poll_datapath #(.DATA_W(8)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .progActive(progActive), .eraseActive(eraseActive),
    .eraseSuspended(eraseSuspended), .timeoutFlag(timeoutFlag),
    .bufAbort(bufAbort), .lastBit7(lastBit7),
    .statusData(statusData), .statusValid(statusValid)
  );
endmodule

// File: rtl/flash_poll_status_chk.sv
module flash_poll_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdStrobe,
  input logic       progActive,
  input logic       eraseActive,
  input logic       eraseSuspended,
  input logic       timeoutFlag,
  input logic       bufAbort,
  input logic       lastBit7,
  input logic [7:0] statusData,
  input logic       statusValid
);
  // R2: operation toggle flips after a read while busy
  assert_op_toggle_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdStrobe) && (progActive || eraseActive)) |=>
      (!(progActive || eraseActive) || statusData[6] != $past(statusData[6])));

  // R3: operation toggle frozen during suspend
  assert_suspend_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseSuspended && !progActive && !eraseActive) |=>
      (!eraseSuspended || progActive || eraseActive || $stable(statusData[6])));

  // R6: data-polling bit while programming
  assert_prog_bit7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    progActive |-> (statusData[7] == !lastBit7));

  // R7: timeout reported while busy
  assert_timeout_bit5_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseActive && timeoutFlag) |-> statusData[5]);

  // R8: abort reported during programming
  assert_abort_bit1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (progActive && bufAbort) |-> statusData[1]);

  // R9: idle hands the bus back to array data
  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!progActive && !eraseActive && !eraseSuspended) |-> (!statusValid && statusData == 8'h00));
endmodule

bind flash_poll_status flash_poll_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rdStrobe(rdStrobe), .progActive(progActive),
  .eraseActive(eraseActive), .eraseSuspended(eraseSuspended),
  .timeoutFlag(timeoutFlag), .bufAbort(bufAbort), .lastBit7(lastBit7),
  .statusData(statusData), .statusValid(statusValid)
);

// File: tb/flash_poll_status_tb_top.sv
module flash_poll_status_tb_top;
  localparam int ADDR_W = 16;
  localparam int SECTOR_SHIFT = 8;
  localparam int SECT_W = ADDR_W - SECTOR_SHIFT;
  localparam logic [SECT_W-1:0] SEL_SEC = 8'h5A;
  localparam logic [SECT_W-1:0] OTH_SEC = 8'h13;
  // {inSector, lastBit7, abort, timeout, suspended, erase, program}
  localparam int NVEC = 14;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0100001, 7'b0100001, 7'b0010001, 7'b0001001,
    7'b1000010, 7'b1000010, 7'b0000010, 7'b1001010,
    7'b1000100, 7'b1000100, 7'b0000100, 7'b1100101,
    7'b1000101, 7'b0000000 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdStrobe = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [SECT_W-1:0] eraseSector = SEL_SEC;
  logic progActive = 1'b0, eraseActive = 1'b0, eraseSuspended = 1'b0;
  logic timeoutFlag = 1'b0, bufAbort = 1'b0, lastBit7 = 1'b0;
  logic [7:0] statusData;
  logic statusValid;

  int errors = 0;
  int checks = 0;
  logic mTog6 = 1'b0;
  logic mTog2 = 1'b0;
  bit done = 1'b0;

  always #4 clk = !clk;

  flash_poll_status #(.ADDR_W(ADDR_W), .SECTOR_SHIFT(SECTOR_SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .eraseSector(eraseSector), .progActive(progActive),
    .eraseActive(eraseActive), .eraseSuspended(eraseSuspended),
    .timeoutFlag(timeoutFlag), .bufAbort(bufAbort), .lastBit7(lastBit7),
    .statusData(statusData), .statusValid(statusValid)
  );

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expWord();
    logic [7:0] w;
    logic v;
    v = progActive || eraseActive || eraseSuspended;
    w = '0;
    w[7] = progActive ? !lastBit7 : (eraseActive ? 1'b0 : 1'b1);
    w[6] = mTog6;
    w[5] = timeoutFlag && (progActive || eraseActive);
    w[2] = mTog2;
    w[1] = bufAbort && progActive;
    return {v, v ? w : 8'h00};
  endfunction

  task automatic setFlags(input logic [6:0] f);
    @(negedge clk);
    {lastBit7, bufAbort, timeoutFlag, eraseSuspended, eraseActive, progActive} = f[5:0];
    rdAddr = {f[6] ? SEL_SEC : OTH_SEC, 8'h21};
  endtask

  // one read: strobe high for hiCycles, sample, drop strobe, update model
  task automatic doRead(input int hiCycles, input string req);
    logic [8:0] e;
    @(negedge clk);
    rdStrobe = 1'b1;
    for (int i = 0; i < hiCycles; i++) @(negedge clk);
    e = expWord();
    check({statusValid, statusData} == e, req, {statusValid, statusData}, e);
    rdStrobe = 1'b0;
    if (progActive || eraseActive) mTog6 = !mTog6;
    if ((eraseActive || eraseSuspended) && rdAddr[ADDR_W-1:SECTOR_SHIFT] == eraseSector)
      mTog2 = !mTog2;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, idle
    check({statusValid, statusData} == 9'h000, "R1", {statusValid, statusData}, 9'h000);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NVEC; k++) begin
      setFlags(VEC[k]);
      doRead(1, "R2/R3/R4/R5/R6/R7/R8/R9 table");
    end

    // R10: long strobe advances only once
    setFlags(7'b1000010);
    doRead(5, "R10 long strobe");
    doRead(1, "R10 after long strobe");

    // R5: program only, in selected sector, bit 2 must not move
    setFlags(7'b1000001);
    doRead(1, "R5 program only");
    doRead(1, "R5 program only repeat");

    // R3: suspended outside sector, both toggles frozen
    setFlags(7'b0000100);
    doRead(1, "R3 suspended outside");
    doRead(1, "R3 suspended outside repeat");

    // R9: idle drives zero even with abort/timeout
    setFlags(7'b1011000);
    doRead(1, "R9 idle masked");

    // R1: reset clears toggle states mid-operation
    setFlags(7'b1000010);
    doRead(1, "R1 pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mTog6 = 1'b0;
    mTog2 = 1'b0;
    @(negedge clk);
    check(statusData[6] == 1'b0 && statusData[2] == 1'b0, "R1 toggles after reset",
          {1'b0, statusData}, 9'h000);
    doRead(1, "R1 read after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule